// File: doc/BRIEF.md
# Corrected Error Report Filter

This block sits between a cache error detector and the status log that records machine errors. It accepts one error event per handshake. Each event carries a line address, a flag that marks it as uncorrected, a transaction type, a hierarchy level and a request type. For each event it decides whether a record is posted to the log, and it builds the 16-bit compound error code that the record carries.

Repeated corrections to the same line say little after the first few. The block keeps recently corrected lines in a small tracking table. Each table entry has a saturating counter. A line is posted only until its count reaches a threshold. The posting that reaches the threshold carries a filter flag, which tells software that later corrections to that line will be withheld. Uncorrected events are never filtered. An uncorrected event also removes its line from the table.

Events arrive on a valid/ready input stream, and records leave on a valid/ready output stream. The output has a single record slot. While a posted record waits for the consumer, `ev_ready` stays low, so events are held back and not dropped. A record is accepted by the consumer in any cycle where `post_valid` and `post_ready` are both high. An event is taken in any cycle where `ev_valid` and `ev_ready` are both high. A synchronous clear input empties the tracking table.

Top module: `corr_err_filter`

## Requirements
- R1: Every posted code has the layout {3'b000, F, 4'b0001, req[3:0], ttype[1:0], level[1:0]}. Bits 15:13 are zero, bit 12 is the filter flag F, and bits 11:8 are 0001. Transaction type: 00 is instruction, 01 is data, 10 is generic. Level: 00 is level 0, 01 is level 1, 11 is generic.
- R2: For a tracked line, corrected events are posted while the line's count is below THRESH (default 3). The posting that brings the count to THRESH has F=1. Earlier postings have F=0.
- R3: Once a line's count has reached THRESH, further corrected events to that line are accepted but produce no posting.
- R4: Every accepted uncorrected event is posted in the next cycle with `post_uncorr`=1 and F=0, whatever the tracking state of its line.
- R5: An uncorrected event to a tracked line invalidates that line's entry. A later correction to the line is counted again from 1.
- R6: While `post_valid` is high and `post_ready` is low, the posted record holds stable and `ev_ready` is low.
- R7: `ev_ready` is high when the output slot is empty or is being drained in the same cycle. A posting caused by an event accepted at a clock edge appears on `post_valid` after that edge.
- R8: A cycle with `clr` high empties the whole tracking table and resets the replacement pointer. `ev_ready` is low during that cycle.
- R9: The table holds ENTRIES lines (default 8). A correction to an untracked line takes the lowest-numbered free entry. If no entry is free, it takes the entry under a round-robin pointer, which then advances.
- R10: After reset, `post_valid` is low, `ev_ready` is high and no line is tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the tracking table |
| ev_valid | input | 1 | Input event valid |
| ev_ready | output | 1 | Block can accept an event |
| ev_addr | input | ADDR_W | Line address of the event |
| ev_uncorr | input | 1 | 1 = uncorrected error, 0 = corrected |
| ev_ttype | input | 2 | Transaction type field |
| ev_level | input | 2 | Hierarchy level field |
| ev_req | input | 4 | Request type field |
| post_valid | output | 1 | Posted record valid |
| post_ready | input | 1 | Consumer accepts the record |
| post_code | output | 16 | Compound error code of the record |
| post_uncorr | output | 1 | Record comes from an uncorrected event |

## Verification
The assertions assume the consumer and the producer follow the handshake. They also assume `clr` is a plain level that the block may see in any cycle. The assertions do not assume that event fields are held while `ev_ready` is low; they check only the block's own outputs. The stimulus drives all inputs on the falling edge. It leaves `ev_valid` high while `ev_ready` is low and retires an event only after a rising edge where both were high. It asserts `clr` only between events, so every sampled outcome has a single expected value.

// File: rtl/cef_pkg.sv
package cef_pkg;

  localparam int CODE_W = 16;

  typedef enum logic [1:0] {
    TT_INSTR   = 2'b00,
    TT_DATA    = 2'b01,
    TT_GENERIC = 2'b10
  } ttype_e;

  typedef enum logic [1:0] {
    LV_L0      = 2'b00,
    LV_L1      = 2'b01,
    LV_GENERIC = 2'b11
  } level_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              uncorr;
  } post_rec_t;

  localparam logic [3:0] CACHE_CLASS = 4'b0001;

endpackage

// File: rtl/cef_code_build.sv
module cef_code_build
  import cef_pkg::*;
(
  input  logic              filt,
  input  logic [3:0]        req,
  input  logic [1:0]        ttype,
  input  logic [1:0]        level,
  output logic [CODE_W-1:0] code
);

  // Cache-hierarchy compound code: zero, filter, class, request, type, level
  always_comb begin
    code        = '0;
    code[12]    = filt;
    code[11:8]  = CACHE_CLASS;
    code[7:4]   = req;
    code[3:2]   = ttype;
    code[1:0]   = level;
  end

endmodule

// File: rtl/cef_track_table.sv
module cef_track_table #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  parameter int THRESH  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               upd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               uncorr,
  output logic               post_req,
  output logic               filt_flag,
  output logic [ENTRIES-1:0] entry_vld
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]           valid_q;
  logic [ADDR_W-1:0]            tag_q [ENTRIES];
  logic [CNT_W-1:0]             cnt_q [ENTRIES];
  logic [IDX_W-1:0]             rr_q;

  logic [ENTRIES-1:0]           hit_vec;
  logic                         hit;
  logic [IDX_W-1:0]             hit_idx;
  logic                         has_free;
  logic [IDX_W-1:0]             free_idx;
  logic [IDX_W-1:0]             alloc_idx;
  logic [CNT_W-1:0]             cur_cnt;
  logic [CNT_W-1:0]             next_cnt;
  logic                         below_max;

  // Parallel tag compare across all entries
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == addr);
  end

  always_comb begin
    hit     = |hit_vec;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  // Lowest free slot: scan from the top so the lowest index wins
  always_comb begin
    has_free = ~&valid_q;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
    alloc_idx = has_free ? free_idx : rr_q;
  end

  assign cur_cnt   = cnt_q[hit_idx];
  assign below_max = cur_cnt < CNT_MAX;
  assign next_cnt  = below_max ? cur_cnt + CNT_ONE : cur_cnt;

  // Posting decision for the event on the input
  always_comb begin
    if (uncorr) begin
      post_req  = 1'b1;
      filt_flag = 1'b0;
    end else if (hit) begin
      post_req  = below_max;
      filt_flag = below_max && (next_cnt == CNT_MAX);
    end else begin
      post_req  = 1'b1;
      filt_flag = (CNT_ONE == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (clr) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (upd_en) begin
      if (uncorr) begin
        if (hit) valid_q[hit_idx] <= 1'b0;
      end else if (!hit) begin
        valid_q[alloc_idx] <= 1'b1;
        if (!has_free) rr_q <= (rr_q == IDX_LAST) ? '0 : rr_q + IDX_W'(1);
      end
    end
  end

  // Tags and counters carry no reset; valid bits qualify them
  always_ff @(posedge clk) begin
    if (upd_en && !clr && !uncorr) begin
      if (hit) begin
        cnt_q[hit_idx] <= next_cnt;
      end else begin
        tag_q[alloc_idx] <= addr;
        cnt_q[alloc_idx] <= CNT_ONE;
      end
    end
  end

  assign entry_vld = valid_q;

endmodule

// File: rtl/cef_post_slot.sv
module cef_post_slot
  import cef_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  post_rec_t rec_in,
  input  logic      post_ready,
  output logic      post_valid,
  output post_rec_t rec_out,
  output logic      slot_free
);

  logic      vld_q;
  post_rec_t rec_q;

  assign slot_free = !vld_q || post_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rec_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      rec_q <= rec_in;
    end else if (post_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign post_valid = vld_q;
  assign rec_out    = rec_q;

endmodule

// File: rtl/corr_err_filter.sv
module corr_err_filter
  import cef_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  parameter int THRESH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_uncorr,
  input  logic [1:0]        ev_ttype,
  input  logic [1:0]        ev_level,
  input  logic [3:0]        ev_req,
  output logic              post_valid,
  input  logic              post_ready,
  output logic [15:0]       post_code,
  output logic              post_uncorr
);

  logic               slot_free;
  logic               accept;
  logic               post_req;
  logic               filt_flag;
  logic [ENTRIES-1:0] entry_vld;
  logic [CODE_W-1:0]  code_nxt;
  post_rec_t          rec_nxt;
  post_rec_t          rec_cur;

  assign ev_ready = slot_free && !clr;
  assign accept   = ev_valid && ev_ready;

  cef_track_table #(
    .ADDR_W (ADDR_W),
    .ENTRIES(ENTRIES),
    .THRESH (THRESH)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .upd_en   (accept),
    .addr     (ev_addr),
    .uncorr   (ev_uncorr),
    .post_req (post_req),
    .filt_flag(filt_flag),
    .entry_vld(entry_vld)
  );

  cef_code_build u_code (
    .filt (filt_flag && !ev_uncorr),
    .req  (ev_req),
    .ttype(ev_ttype),
    .level(ev_level),
    .code (code_nxt)
  );

  assign rec_nxt.code   = code_nxt;
  assign rec_nxt.uncorr = ev_uncorr;

  cef_post_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && post_req),
    .rec_in    (rec_nxt),
    .post_ready(post_ready),
    .post_valid(post_valid),
    .rec_out   (rec_cur),
    .slot_free (slot_free)
  );

  assign post_code   = rec_cur.code;
  assign post_uncorr = rec_cur.uncorr;

endmodule

// File: rtl/cef_checker.sv
module cef_checker #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               ev_valid,
  input logic               ev_ready,
  input logic               ev_uncorr,
  input logic               post_valid,
  input logic               post_ready,
  input logic [15:0]        post_code,
  input logic               post_uncorr,
  input logic [ENTRIES-1:0] entry_vld
);

  assert_code_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> (post_code[15:13] == 3'b000) && (post_code[11:8] == 4'b0001));

  assert_uncorr_unflagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid && post_uncorr |-> !post_code[12]);

  assert_uncorr_posted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_uncorr |=> post_valid && post_uncorr);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid && !post_ready |=> post_valid && $stable(post_code) && $stable(post_uncorr));

  assert_stall_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid && !post_ready |-> !ev_ready);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> entry_vld == '0);

  assert_clear_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !ev_ready);

endmodule

bind corr_err_filter cef_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .ev_valid   (ev_valid),
  .ev_ready   (ev_ready),
  .ev_uncorr  (ev_uncorr),
  .post_valid (post_valid),
  .post_ready (post_ready),
  .post_code  (post_code),
  .post_uncorr(post_uncorr),
  .entry_vld  (entry_vld)
);

// File: tb/corr_err_filter_bench.sv
module corr_err_filter_bench;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          ev_valid = 1'b0;
  logic          ev_ready;
  logic [AW-1:0] ev_addr = '0;
  logic          ev_uncorr = 1'b0;
  logic [1:0]    ev_ttype = '0;
  logic [1:0]    ev_level = '0;
  logic [3:0]    ev_req = '0;
  logic          post_valid;
  logic          post_ready = 1'b1;
  logic [15:0]   post_code;
  logic          post_uncorr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10ns clk = ~clk;

  corr_err_filter u_corr_err_filter (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
    .ev_uncorr(ev_uncorr), .ev_ttype(ev_ttype), .ev_level(ev_level), .ev_req(ev_req),
    .post_valid(post_valid), .post_ready(post_ready),
    .post_code(post_code), .post_uncorr(post_uncorr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic f, input logic [3:0] rq,
                                     input logic [1:0] tt, input logic [1:0] ll);
    return {3'b000, f, 4'b0001, rq, tt, ll};
  endfunction

  // Offer one event, wait for its acceptance, then check the outcome
  task automatic send(input logic [AW-1:0] a, input logic uc, input logic [1:0] tt,
                      input logic [1:0] ll, input logic [3:0] rq,
                      input logic ep, input logic ef, input string tag);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_addr = a; ev_uncorr = uc;
    ev_ttype = tt; ev_level = ll; ev_req = rq;
    @(negedge clk);
    ev_valid = 1'b0;
    chk(post_valid == ep, {tag, " post_valid"}, 32'(post_valid), 32'(ep));
    if (ep) begin
      chk(post_code == mk(ef, rq, tt, ll), {tag, " code"}, 32'(post_code), 32'(mk(ef, rq, tt, ll)));
      chk(post_uncorr == uc, {tag, " uncorr"}, 32'(post_uncorr), 32'(uc));
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    #1;
    chk(ev_ready == 1'b0, "R8 ev_ready low in clear", 32'(ev_ready), 0);
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(post_valid == 1'b0, "R10 post_valid after reset", 32'(post_valid), 0);
    chk(ev_ready == 1'b1, "R10 ev_ready after reset", 32'(ev_ready), 1);
    send(32'h40, 1'b0, 2'b01, 2'b01, 4'h1, 1'b1, 1'b0, "R10 first correction untracked");
  endtask

  task automatic t_threshold();
    do_clear();
    send(32'hA0, 1'b0, 2'b01, 2'b00, 4'h3, 1'b1, 1'b0, "R2 corr 1");
    send(32'hA0, 1'b0, 2'b01, 2'b00, 4'h3, 1'b1, 1'b0, "R2 corr 2");
    send(32'hA0, 1'b0, 2'b01, 2'b00, 4'h3, 1'b1, 1'b1, "R2 corr 3 flagged");
    send(32'hA0, 1'b0, 2'b01, 2'b00, 4'h3, 1'b0, 1'b0, "R3 corr 4 suppressed");
    send(32'hA0, 1'b0, 2'b00, 2'b01, 4'h5, 1'b0, 1'b0, "R3 corr 5 suppressed");
    send(32'hA4, 1'b0, 2'b01, 2'b00, 4'h3, 1'b1, 1'b0, "R2 other line unaffected");
  endtask

  task automatic t_uncorr();
    send(32'hA0, 1'b1, 2'b01, 2'b00, 4'h6, 1'b1, 1'b0, "R4 uncorr on saturated line");
    send(32'hA0, 1'b0, 2'b01, 2'b00, 4'h3, 1'b1, 1'b0, "R5 count restarts 1");
    send(32'hA0, 1'b0, 2'b01, 2'b00, 4'h3, 1'b1, 1'b0, "R5 count restarts 2");
    send(32'hA0, 1'b0, 2'b01, 2'b00, 4'h3, 1'b1, 1'b1, "R5 count restarts 3");
    send(32'hBB, 1'b1, 2'b10, 2'b11, 4'hF, 1'b1, 1'b0, "R4 uncorr untracked");
  endtask

  task automatic t_fields();
    send(32'hC0, 1'b0, 2'b10, 2'b11, 4'hA, 1'b1, 1'b0, "R1 generic fields");
    send(32'hC4, 1'b0, 2'b00, 2'b01, 4'h0, 1'b1, 1'b0, "R1 instr L1");
    send(32'hC8, 1'b0, 2'b01, 2'b00, 4'hF, 1'b1, 1'b0, "R1 data L0");
  endtask

  task automatic t_backpressure();
    logic [15:0] held;
    @(negedge clk);
    post_ready = 1'b0;
    ev_valid = 1'b1; ev_addr = 32'hD0; ev_uncorr = 1'b0;
    ev_ttype = 2'b01; ev_level = 2'b01; ev_req = 4'h2;
    @(negedge clk);
    chk(post_valid == 1'b1, "R7 posted after one edge", 32'(post_valid), 1);
    held = mk(1'b0, 4'h2, 2'b01, 2'b01);
    chk(post_code == held, "R7 first record code", 32'(post_code), 32'(held));
    ev_addr = 32'hD4; ev_uncorr = 1'b1; ev_req = 4'h9;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(post_valid == 1'b1 && post_code == held, "R6 record held", 32'(post_code), 32'(held));
      chk(ev_ready == 1'b0, "R6 input stalled", 32'(ev_ready), 0);
    end
    post_ready = 1'b1;
    #1;
    chk(ev_ready == 1'b1, "R7 ready while draining", 32'(ev_ready), 1);
    @(negedge clk);
    ev_valid = 1'b0;
    chk(post_valid == 1'b1 && post_uncorr == 1'b1, "R7 stalled event posted", 32'(post_uncorr), 1);
    chk(post_code == mk(1'b0, 4'h9, 2'b01, 2'b01), "R7 stalled event code",
        32'(post_code), 32'(mk(1'b0, 4'h9, 2'b01, 2'b01)));
    @(negedge clk);
    chk(post_valid == 1'b0, "R7 slot drained", 32'(post_valid), 0);
  endtask

  task automatic t_clear();
    do_clear();
    send(32'hE0, 1'b0, 2'b00, 2'b00, 4'h1, 1'b1, 1'b0, "R8 pre-clear 1");
    send(32'hE0, 1'b0, 2'b00, 2'b00, 4'h1, 1'b1, 1'b0, "R8 pre-clear 2");
    do_clear();
    send(32'hE0, 1'b0, 2'b00, 2'b00, 4'h1, 1'b1, 1'b0, "R8 line forgotten after clear");
  endtask

  task automatic t_replace();
    do_clear();
    for (int i = 0; i < 8; i++) begin
      send(32'h100 + 32'(i), 1'b0, 2'b01, 2'b01, 4'h4, 1'b1, 1'b0, "R9 fill a");
      send(32'h100 + 32'(i), 1'b0, 2'b01, 2'b01, 4'h4, 1'b1, 1'b0, "R9 fill b");
    end
    send(32'h200, 1'b0, 2'b01, 2'b01, 4'h4, 1'b1, 1'b0, "R9 new line evicts entry 0");
    send(32'h101, 1'b0, 2'b01, 2'b01, 4'h4, 1'b1, 1'b1, "R9 entry 1 still tracked");
    send(32'h100, 1'b0, 2'b01, 2'b01, 4'h4, 1'b1, 1'b0, "R9 evicted line is new");
    send(32'h101, 1'b0, 2'b01, 2'b01, 4'h4, 1'b1, 1'b0, "R9 second eviction by pointer");
    send(32'h103, 1'b0, 2'b01, 2'b01, 4'h4, 1'b1, 1'b1, "R9 entry 3 still tracked");
    send(32'h200, 1'b1, 2'b01, 2'b01, 4'h7, 1'b1, 1'b0, "R4 uncorr frees entry 0");
    send(32'h300, 1'b0, 2'b01, 2'b01, 4'h4, 1'b1, 1'b0, "R9 lowest free used");
    send(32'h104, 1'b0, 2'b01, 2'b01, 4'h4, 1'b1, 1'b1, "R9 pointer kept on free use");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_uncorr();
    t_fields();
    t_backpressure();
    t_clear();
    t_replace();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #2ms;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule